// File: doc/BRIEF.md
# Selectable-Order Sinc Decimator with Accumulate-and-Dump Integrator

This block turns a strobed stream of small signed samples, such as the output of a sigma-delta modulator, into wide signed results at a much lower rate. It has two stages. The first is a sinc decimation filter. Its order is chosen at run time from one to five, and a FastSinc setting gives a second-order response at twice the gain. That stage keeps one filtered value out of every FOSR accepted samples. The second stage adds up IOSR consecutive filtered values. It then presents the sum with a one-cycle valid pulse and starts the next sum from zero.

The filter is built as a chain of running-sum stages at the sample rate, followed by a decimator and a chain of first-difference stages. All arithmetic is two's-complement with wraparound, one width throughout. That width is derived from the parameters so that the largest possible gain (fifth order at the largest FOSR, summed over the largest IOSR, at full-scale input) fits exactly. The order, FOSR and IOSR inputs are expected to stay static while the block runs. Any change to them restarts the whole block from empty.

Top module: `sinc_decim_integ`

## Requirements
- R1: While rst_n is low at a clock edge, and after that edge, out_vld is 0 and out_data is 0.
- R2: A sample is taken only at an edge where in_vld is 1. At edges with in_vld low, in_data has no effect on any later result.
- R3: The filter produces one decimated value for every FOSR accepted samples. A fosr value of 0 behaves as 1.
- R4: With order code k from 1 to 5, each decimated value is the accepted input convolved with k cascaded length-FOSR boxcars. The sequence starts from all-zero history at the last reset or clear, and the settled gain is FOSR^k. Codes 6 and 7 behave as code 5.
- R5: Order code 0 selects FastSinc. Its decimated values are exactly twice the order-2 values, so the settled gain is 2·FOSR².
- R6: The result is the sum of IOSR consecutive decimated values. out_vld is high for one cycle per result, and the next sum starts from zero. An iosr value of 0 behaves as 1. out_data holds the last result between pulses.
- R7: out_vld is high in the second clock cycle after the edge that accepts the sample closing a result.
- R8: At any edge where order, fosr or iosr differs from its value at the previous edge, all filter and integrator state is cleared. The sample offered at that edge is dropped, any result still in flight is discarded, and after that edge out_vld is 0 and out_data is 0.
- R9: out_data is DIN_W + 5·ceil(log2 MAX_FOSR) + ceil(log2 MAX_IOSR) + 1 bits wide, and every result is exact. For example, order 3 at FOSR 256 with a constant input of +1 settles to 67108864 when IOSR is 4, to 536870912 when IOSR is 32 and to 2147483648 when IOSR is 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Sample strobe |
| in_data | input | DIN_W | Signed input sample |
| order | input | 3 | Filter selection: 0 FastSinc, 1 to 5 sinc order, 6 and 7 as 5 |
| fosr | input | clog2(MAX_FOSR+1) | Decimation ratio of the filter |
| iosr | input | clog2(MAX_IOSR+1) | Number of decimated values per result |
| out_vld | output | 1 | One-cycle pulse marking a new result |
| out_data | output | OUT_W | Signed result, held until the next pulse |

## Verification
The bench builds the block with DIN_W 4, MAX_FOSR 256 and MAX_IOSR 256, which makes out_data 53 bits wide. With these values, full-scale constant inputs at order 3 and FOSR 256 can reach results of 2^31. The same build also covers short ratios, where fourth- and fifth-order responses settle within a few dozen samples, and fosr and iosr values of 0 and 1, where every sample yields a result. A configuration change can also land at every offset inside a decimation group and inside an integration group.

// File: rtl/sdec_pkg.sv
// Shared constants and order decoding for the sinc decimator.
// Assumes order codes: 0 = FastSinc, 1..5 = sinc order, 6/7 = order 5.
package sdec_pkg;

    localparam int NSTG = 5;

    localparam logic [2:0] ORD_FAST = 3'd0;

    // Index of the last integrator/comb stage used by an order code.
    function automatic logic [2:0] last_stage(input logic [2:0] code);
        logic [2:0] idx;
        case (code)
            3'd0:    idx = 3'd1;
            3'd1:    idx = 3'd0;
            3'd2:    idx = 3'd1;
            3'd3:    idx = 3'd2;
            3'd4:    idx = 3'd3;
            default: idx = 3'd4;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/sdec_integrators.sv
// Cascade of running-sum stages at the input sample rate.
// Exposes the value every stage takes on if the current sample is accepted,
// so the decimator can capture the updated sums in the same cycle.
// Assumes W is wide enough that wraparound cancels in the comb section.
module sdec_integrators #(
    parameter int W     = 53,
    parameter int DIN_W = 4,
    parameter int NS    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       in_vld,
    input  logic signed [DIN_W-1:0]    in_data,
    output logic [NS-1:0][W-1:0]       nxt
);

    logic [NS-1:0][W-1:0] sum_q;
    logic [W-1:0]         xin;
    logic [W-1:0]         run;

    // Sign-extend the sample and chain the would-be sums stage by stage.
    always_comb begin
        xin = {{(W-DIN_W){in_data[DIN_W-1]}}, in_data};
        run = xin;
        for (int s = 0; s < NS; s++) begin
            run    = sum_q[s] + run;
            nxt[s] = run;
        end
    end

    // Commit the new sums on an accepted sample; clear on reset or config change.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_q <= '0;
        end else if (in_vld) begin
            sum_q <= nxt;
        end
    end

    // R2: without a strobe the running sums do not move.
    a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld && !clr) |=> $stable(sum_q));

endmodule

// File: rtl/sdec_combs.sv
// Cascade of first-difference stages running at the decimated rate.
// On a take pulse it differences the captured integrator value through
// every stage and registers the output of the stage picked by the order.
// FastSinc doubles the second-stage output.
module sdec_combs #(
    parameter int W  = 53,
    parameter int NS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          take,
    input  logic [W-1:0]  src,
    input  logic [2:0]    sel,
    input  logic          fast,
    output logic          f_vld,
    output logic [W-1:0]  f_data
);

    logic [NS-1:0][W-1:0] dly_q;
    logic [NS-1:0][W-1:0] stg_in;
    logic [NS-1:0][W-1:0] diff;
    logic [W-1:0]         run;
    logic [W-1:0]         pick;

    // Difference each stage against its stored previous input.
    always_comb begin
        run = src;
        for (int s = 0; s < NS; s++) begin
            stg_in[s] = run;
            diff[s]   = run - dly_q[s];
            run       = diff[s];
        end
        pick = fast ? {diff[sel][W-2:0], 1'b0} : diff[sel];
    end

    // Store the stage inputs and the selected output once per decimation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            dly_q  <= '0;
            f_vld  <= 1'b0;
            f_data <= '0;
        end else begin
            f_vld <= take;
            if (take) begin
                dly_q  <= stg_in;
                f_data <= pick;
            end
        end
    end

    // R3: a decimated value appears exactly one cycle after a take.
    a_r3_value_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr) |=> f_vld);
    a_r3_no_value_without_take: assert property (@(posedge clk) disable iff (!rst_n)
        f_vld |-> $past(take));

endmodule

// File: rtl/sdec_dump.sv
// Accumulate-and-dump stage: sums a programmable count of decimated values,
// registers the total with a one-cycle valid, then restarts from zero.
// Assumes iosr_m1 is stable except at edges where clr is raised.
module sdec_dump #(
    parameter int W  = 53,
    parameter int IW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          f_vld,
    input  logic [W-1:0]  f_data,
    input  logic [IW-1:0] iosr_m1,
    output logic          o_vld,
    output logic [W-1:0]  o_data
);

    logic [W-1:0]  acc_q;
    logic [IW-1:0] gcnt_q;

    // Add each decimated value; on the last of a group emit and restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q  <= '0;
            gcnt_q <= '0;
            o_vld  <= 1'b0;
            o_data <= '0;
        end else begin
            o_vld <= 1'b0;
            if (f_vld) begin
                if (gcnt_q == iosr_m1) begin
                    o_data <= acc_q + f_data;
                    o_vld  <= 1'b1;
                    acc_q  <= '0;
                    gcnt_q <= '0;
                end else begin
                    acc_q  <= acc_q + f_data;
                    gcnt_q <= gcnt_q + IW'(1);
                end
            end
        end
    end

    // R6: the sum is empty in the cycle its result is presented.
    a_r6_empty_after_dump: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld |-> (acc_q == '0 && gcnt_q == '0));
    // R6: the group counter never passes the programmed length.
    a_r6_group_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (gcnt_q <= iosr_m1));
    // R6: no result without a decimated value feeding it.
    a_r6_result_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        !f_vld |=> !o_vld);

endmodule

// File: rtl/sinc_decim_integ.sv
// Selectable-order sinc decimator followed by an accumulate-and-dump stage.
// Detects any change of order/fosr/iosr and clears every stage on it.
// Assumes the datapath width OUT_W covers fifth order at MAX_FOSR, summed
// over MAX_IOSR, at full-scale input.
module sinc_decim_integ
    import sdec_pkg::*;
#(
    parameter int DIN_W    = 4,
    parameter int MAX_FOSR = 256,
    parameter int MAX_IOSR = 256,
    localparam int FW      = $clog2(MAX_FOSR + 1),
    localparam int IW      = $clog2(MAX_IOSR + 1),
    localparam int OUT_W   = DIN_W + NSTG * $clog2(MAX_FOSR) + $clog2(MAX_IOSR) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic signed [DIN_W-1:0]  in_data,
    input  logic [2:0]               order,
    input  logic [FW-1:0]            fosr,
    input  logic [IW-1:0]            iosr,
    output logic                     out_vld,
    output logic signed [OUT_W-1:0]  out_data
);

    localparam int CW = 3 + FW + IW;

    logic [CW-1:0]              cfg_now;
    logic [CW-1:0]              cfg_q;
    logic                       chg;
    logic [FW-1:0]              fosr_m1;
    logic [IW-1:0]              iosr_m1;
    logic [FW-1:0]              dcnt_q;
    logic                       last;
    logic                       take;
    logic [2:0]                 sel;
    logic                       fast;
    logic [NSTG-1:0][OUT_W-1:0] nxt;
    logic [OUT_W-1:0]           src;
    logic                       f_vld;
    logic [OUT_W-1:0]           f_data;
    logic [OUT_W-1:0]           o_data;

    // Decode the configuration and the decimation boundary.
    always_comb begin
        cfg_now = {order, fosr, iosr};
        chg     = (cfg_now != cfg_q);
        fosr_m1 = (fosr == '0) ? '0 : fosr - FW'(1);
        iosr_m1 = (iosr == '0) ? '0 : iosr - IW'(1);
        last    = (dcnt_q == fosr_m1);
        take    = in_vld && last && !chg;
        sel     = last_stage(order);
        fast    = (order == ORD_FAST);
        src     = nxt[sel];
    end

    // Remember the configuration seen at the previous edge.
    always_ff @(posedge clk) begin
        cfg_q <= cfg_now;
    end

    // Count accepted samples within the current decimation group.
    always_ff @(posedge clk) begin
        if (!rst_n || chg) begin
            dcnt_q <= '0;
        end else if (in_vld) begin
            dcnt_q <= last ? '0 : dcnt_q + FW'(1);
        end
    end

    sdec_integrators #(.W(OUT_W), .DIN_W(DIN_W), .NS(NSTG)) u_int (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (chg),
        .in_vld  (in_vld),
        .in_data (in_data),
        .nxt     (nxt)
    );

    sdec_combs #(.W(OUT_W), .NS(NSTG)) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (chg),
        .take   (take),
        .src    (src),
        .sel    (sel),
        .fast   (fast),
        .f_vld  (f_vld),
        .f_data (f_data)
    );

    sdec_dump #(.W(OUT_W), .IW(IW)) u_dump (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (chg),
        .f_vld   (f_vld),
        .f_data  (f_data),
        .iosr_m1 (iosr_m1),
        .o_vld   (out_vld),
        .o_data  (o_data)
    );

    assign out_data = $signed(o_data);

    // R8: a configuration change empties the output path.
    a_r8_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (!out_vld && out_data == '0));
    // R3: the decimation counter stays inside the programmed ratio.
    a_r3_group_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !chg |-> (dcnt_q <= fosr_m1));
    // R1: reset leaves no result behind.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && out_data == '0));

endmodule

// File: tb/sim_sinc_decim_integ.sv
`timescale 1ns/1ps
module sim_sinc_decim_integ;

    localparam int DIN_W    = 4;
    localparam int MAX_FOSR = 256;
    localparam int MAX_IOSR = 256;
    localparam int FW       = 9;
    localparam int IW       = 9;
    localparam int OUT_W    = DIN_W + 5 * 8 + 8 + 1;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic                    in_vld;
    logic signed [DIN_W-1:0] in_data;
    logic [2:0]              order;
    logic [FW-1:0]           fosr;
    logic [IW-1:0]           iosr;
    logic                    out_vld;
    logic signed [OUT_W-1:0] out_data;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_on = 0;
    string req = "R1";

    always #2.5 clk = ~clk;

    sinc_decim_integ #(.DIN_W(DIN_W), .MAX_FOSR(MAX_FOSR), .MAX_IOSR(MAX_IOSR)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
        .order(order), .fosr(fosr), .iosr(iosr),
        .out_vld(out_vld), .out_data(out_data)
    );

    // ---------------- behavioural reference model ----------------
    longint h[$];
    longint hist[$];
    int     m_L, m_G, m_n;
    bit     m_fast;
    int     m_cnt, m_gcnt;
    longint m_acc;
    bit     pend;
    longint pend_d;
    bit     e_v;
    longint e_hold;
    logic [3+FW+IW-1:0] prev_cfg;

    function automatic void build_kernel(int n, int L);
        longint tmp[$];
        longint s;
        h.delete();
        h.push_back(1);
        repeat (n) begin
            tmp.delete();
            for (int i = 0; i < h.size() + L - 1; i++) begin
                s = 0;
                for (int j = 0; j < L; j++)
                    if (i - j >= 0 && i - j < h.size()) s += h[i - j];
                tmp.push_back(s);
            end
            h = tmp;
        end
    endfunction

    function automatic longint convolve();
        longint s;
        s = 0;
        for (int t = 0; t < hist.size(); t++) s += h[t] * hist[t];
        return s;
    endfunction

    function automatic void model_clear();
        m_fast = (order == 3'd0);
        m_n    = (order == 3'd0) ? 2 : (order > 3'd5 ? 5 : int'(order));
        m_L    = (fosr == 0) ? 1 : int'(fosr);
        m_G    = (iosr == 0) ? 1 : int'(iosr);
        build_kernel(m_n, m_L);
        hist.delete();
        m_cnt = 0; m_gcnt = 0; m_acc = 0;
        pend = 0; pend_d = 0; e_v = 0; e_hold = 0;
    endfunction

    always @(posedge clk) begin
        bit     np;
        longint nd;
        longint y;
        np = 0; nd = 0;
        if (!rst_n || ({order, fosr, iosr} != prev_cfg)) begin
            model_clear();
        end else begin
            if (in_vld) begin
                hist.push_front(longint'(in_data));
                if (hist.size() > h.size()) void'(hist.pop_back());
                m_cnt++;
                if (m_cnt == m_L) begin
                    m_cnt = 0;
                    y = convolve();
                    if (m_fast) y = 2 * y;
                    if (m_gcnt == m_G - 1) begin
                        np = 1; nd = m_acc + y; m_acc = 0; m_gcnt = 0;
                    end else begin
                        m_acc += y; m_gcnt++;
                    end
                end
            end
            e_v = pend;
            if (pend) e_hold = pend_d;
            pend = np; pend_d = nd;
        end
        prev_cfg = {order, fosr, iosr};
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (cmp_on) begin
            n_cmp++;
            if (out_vld !== e_v || longint'(out_data) !== e_hold) begin
                n_bad++;
                $display("FAIL %s: cycle compare vld/data actual %0b/%0d expected %0b/%0d",
                         req, out_vld, longint'(out_data), e_v, e_hold);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] o, input int f, input int i);
        @(negedge clk);
        in_vld = 1'b0;
        order  = o;
        fosr   = FW'(f);
        iosr   = IW'(i);
    endtask

    // mode 0: random data, strobe gaps; 1: random, continuous; 2: constant, continuous
    task automatic drive(input int cycles, input int mode, input int cval);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            in_vld  = (mode == 0) ? (($urandom % 3) != 0) : 1'b1;
            in_data = (mode == 2) ? DIN_W'(cval) : DIN_W'($urandom);
        end
    endtask

    task automatic idle(input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            in_vld  = 1'b0;
            in_data = DIN_W'($urandom);
        end
    endtask

    task automatic peak(input string tag, input longint exp);
        idle(3);
        check(longint'(out_data) == exp, tag, longint'(out_data), exp);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        rst_n = 1'b0; in_vld = 1'b0; in_data = '0;
        order = 3'd1; fosr = FW'(8); iosr = IW'(3);
        repeat (4) @(negedge clk);
        check(out_vld == 1'b0 && out_data == '0, "R1 during reset", longint'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_vld == 1'b0 && out_data == '0, "R1 after reset", longint'(out_data), 0);
        cmp_on = 1;

        req = "R2 R3 R4 R6 sinc1";
        drive(200, 0, 0); idle(3);
        set_cfg(3'd2, 5, 2);
        req = "R2 R4 sinc2";
        drive(200, 0, 0); idle(3);
        set_cfg(3'd0, 5, 2);
        req = "R5 fastsinc random";
        drive(200, 0, 0);

        set_cfg(3'd0, 4, 3);
        req = "R5 fastsinc peak";
        drive(48, 2, 7);
        peak("R5 fastsinc peak", 2 * 16 * 3 * 7);

        set_cfg(3'd4, 6, 2);
        req = "R4 sinc4 peak";
        drive(72, 2, -8);
        peak("R4 sinc4 peak", -8 * 1296 * 2);

        set_cfg(3'd5, 4, 5);
        req = "R4 sinc5 peak";
        drive(60, 2, 7);
        peak("R4 sinc5 peak", 7 * 1024 * 5);

        set_cfg(3'd7, 3, 1);
        req = "R4 code7 as sinc5";
        drive(100, 0, 0); idle(3);

        set_cfg(3'd3, 0, 0);
        req = "R3 R6 ratio zero";
        drive(50, 1, 0); idle(3);
        // R7: exact latency and one-cycle pulse
        @(negedge clk); in_vld = 1'b1; in_data = DIN_W'(5);
        @(negedge clk); in_vld = 1'b0;
        check(out_vld == 1'b0, "R7 not yet valid", out_vld, 0);
        @(negedge clk);
        check(out_vld == 1'b1 && out_data == 5, "R7 second cycle", longint'(out_data), 5);
        @(negedge clk);
        check(out_vld == 1'b0 && out_data == 5, "R6 pulse one cycle and hold", out_vld, 0);

        req = "R8 config change";
        for (int off = 0; off < 16; off++) begin
            set_cfg(3'd2, 4, 3);
            drive(off + 12, 1, 0);
            @(negedge clk);
            order = 3'd2; fosr = FW'(4); iosr = IW'(2);
            in_vld = 1'b1; in_data = DIN_W'($urandom);
            @(negedge clk);
            in_vld = 1'b0;
            check(out_vld == 1'b0 && out_data == '0, "R8 cleared after change", longint'(out_data), 0);
            drive(20, 1, 0);
        end
        idle(3);

        set_cfg(3'd3, 256, 4);
        req = "R9 sinc3 256 x4";
        drive(2048, 2, 1);
        peak("R9 sinc3 256 x4", 64'd67108864);
        set_cfg(3'd3, 256, 32);
        req = "R9 sinc3 256 x32";
        drive(16384, 2, 1);
        peak("R9 sinc3 256 x32", 64'd536870912);
        set_cfg(3'd3, 256, 128);
        req = "R9 sinc3 256 x128";
        drive(65536, 2, 1);
        peak("R9 sinc3 256 x128", 64'd2147483648);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule